// File: doc/BRIEF.md
# Sparse Hit Readout Buffer with Double-Rate Serial Output

This block collects digitized hit words from front-end channels that have fired. Each word holds a 6-bit channel number, a 10-bit amplitude and a 10-bit time value. Words go into a small first-in first-out store. A serializer takes them out one at a time and ships each word off chip over two serial lanes. Only channels that registered a hit produce words, so the readout is sparse.

One storage slot can be freed and another filled at the same clock edge. The serializer therefore keeps draining while new hits arrive. Each lane presents one bit while the clock is high and another while it is low. With a 200 MHz clock and two lanes, this gives an aggregate of 800 Mbps. A frame strobe marks the start of every word. The lanes rest at zero whenever no word is in flight.

Top module: `hit_readout_ddr`

## Requirements
- R1: After reset, `empty_o` is 1, `full_o` is 0, `overflow_o` is 0, `frame_o` is 0, and both lanes are 0 in both clock phases.
- R2: A sent word is 28 bits wide. Bits 27:22 hold the channel, bits 21:12 the amplitude, bits 11:2 the time, and bits 1:0 are zero. Bit 27 is sent first.
- R3: A word takes 7 clock cycles. In its cycle c (0..6), while the clock is high, lane 0 carries word bit 27-4c and lane 1 carries bit 26-4c. While the clock is low, lane 0 carries bit 25-4c and lane 1 carries bit 24-4c.
- R4: `frame_o` is 1 during the first clock cycle of each word and 0 during the other six.
- R5: Suppose a hit is written at clock edge E into an empty, idle buffer with `rd_en_i` high. Its first cycle on the lanes is the cycle that follows edge E+1.
- R6: While `rd_en_i` stays high and words are queued, each word starts in the cycle right after the previous word's last cycle, with no idle cycle between them.
- R7: When no word is being sent, both lanes are 0 in both phases and `frame_o` is 0. This holds when the buffer is empty and when `rd_en_i` is low.
- R8: The buffer holds 4 words and sends them in the order they were written. `full_o` is 1 when 4 words are held, and `empty_o` is 1 when none are held.
- R9: A write while the buffer is full, with no read at the same edge, is dropped. It sets `overflow_o`, which stays 1 until reset.
- R10: A write at the same edge as a read from a full buffer is accepted, and `overflow_o` does not change.
- R11: If `rd_en_i` goes low, the word already being sent completes, and no new word starts until `rd_en_i` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz clock; both phases carry data |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid_i | input | 1 | Hit word present on the write fields |
| wr_chan_i | input | 6 | Channel number of the hit |
| wr_amp_i | input | 10 | Digitized amplitude |
| wr_time_i | input | 10 | Digitized time |
| rd_en_i | input | 1 | Allow the serializer to start new words |
| lane_o | output | 2 | Double-rate serial lanes |
| frame_o | output | 1 | High in the first cycle of each word |
| empty_o | output | 1 | Buffer holds no words |
| full_o | output | 1 | Buffer holds 4 words |
| overflow_o | output | 1 | Sticky flag for a dropped write |

## Verification
A write into the buffer and the removal of a word by the serializer can fall on the same clock edge. This matters most when all four slots are occupied. The bench fills the buffer with `rd_en_i` low. It then raises `rd_en_i` and presents a fifth hit in the same cycle, so the load edge of the serializer coincides with the write edge. The outcome is judged at the ports: `full_o` stays 1 and `overflow_o` stays 0, and all five words then appear on the lanes in write order with no gaps between them.

// File: rtl/hro_pkg.sv
package hro_pkg;
    localparam int CH_W  = 6;
    localparam int VAL_W = 10;

    typedef struct packed {
        logic [CH_W-1:0]  chan;
        logic [VAL_W-1:0] amp;
        logic [VAL_W-1:0] tdc;
    } hit_t;

    localparam int PAY_W = $bits(hit_t);
endpackage

// File: rtl/hro_fifo.sv
module hro_fifo
    import hro_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  hit_t push_data_i,
    input  logic pop_i,
    output hit_t pop_data_o,
    output logic empty_o,
    output logic full_o,
    output logic ovf_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        hit_t [DEPTH-1:0] mem;
        logic [AW-1:0]    wptr;
        logic [AW-1:0]    rptr;
        logic [CW-1:0]    cnt;
        logic             ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     push_ok;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        // a slot freed at this edge may be refilled at the same edge
        push_ok = push_i && (!full_o || pop_i);
        if (pop_i) begin
            st_d.rptr = ptr_inc(st_q.rptr);
        end
        if (push_ok) begin
            st_d.mem[st_q.wptr] = push_data_i;
            st_d.wptr           = ptr_inc(st_q.wptr);
        end
        st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_i);
        if (push_i && !push_ok) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pop_data_o = st_q.mem[st_q.rptr];
    assign empty_o    = (st_q.cnt == '0);
    assign full_o     = (st_q.cnt == CW'(DEPTH));
    assign ovf_o      = st_q.ovf;

    // R8: the flags never both hold, and nothing is taken from an empty store
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_o && full_o));
    a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
    // R9: a dropped write leaves the fill level alone and raises the flag
    a_r9_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> $stable(st_q.cnt));
    a_r9_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> ovf_o);
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
    // R10: a read and a write together on a full store keep it full, no flag
    a_r10_swap_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && full_o && !ovf_o) |=> (full_o && !ovf_o));
endmodule

// File: rtl/hro_ser.sv
module hro_ser
    import hro_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en_i,
    input  logic             word_ok_i,
    input  hit_t             word_i,
    output logic             pop_o,
    output logic             frame_o,
    output logic [LANES-1:0] lane_o
);
    localparam int BPC    = 2 * LANES;
    localparam int CYC    = (PAY_W + BPC - 1) / BPC;
    localparam int WORD_W = CYC * BPC;
    localparam int PAD_W  = WORD_W - PAY_W;
    localparam int CNT_W  = (CYC > 1) ? $clog2(CYC) : 1;

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic    last, load;

    always_comb begin
        st_d = st_q;
        last = st_q.busy && (st_q.cnt == CNT_W'(CYC - 1));
        load = rd_en_i && word_ok_i && (!st_q.busy || last);
        if (load) begin
            st_d.sh   = WORD_W'(word_i) << PAD_W;
            st_d.cnt  = '0;
            st_d.busy = 1'b1;
        end else if (st_q.busy) begin
            st_d.sh = st_q.sh << BPC;
            if (last) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pop_o   = load;
    assign frame_o = st_q.busy && (st_q.cnt == '0);

    // each lane: high phase bit, then low phase bit, lanes interleaved
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic rise_b, fall_b;
        assign rise_b    = st_q.busy & st_q.sh[WORD_W-1-l];
        assign fall_b    = st_q.busy & st_q.sh[WORD_W-1-LANES-l];
        assign lane_o[l] = clk ? rise_b : fall_b;
    end

    // R3: the beat counter stays inside one word
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(CYC));
    // R4: the frame strobe lasts one cycle
    a_r4_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |=> !frame_o);
    // R6: a queued word follows the last beat at once
    a_r6_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (last && rd_en_i && word_ok_i) |=> frame_o);
    // R11: with reads disabled an idle serializer stays idle
    a_r11_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en_i && !st_q.busy) |=> !st_q.busy);
endmodule

// File: rtl/hit_readout_ddr.sv
module hit_readout_ddr
    import hro_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid_i,
    input  logic [CH_W-1:0]  wr_chan_i,
    input  logic [VAL_W-1:0] wr_amp_i,
    input  logic [VAL_W-1:0] wr_time_i,
    input  logic             rd_en_i,
    output logic [LANES-1:0] lane_o,
    output logic             frame_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             overflow_o
);
    hit_t in_hit, head_hit;
    logic pop;

    assign in_hit = '{chan: wr_chan_i, amp: wr_amp_i, tdc: wr_time_i};

    hro_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (wr_valid_i),
        .push_data_i (in_hit),
        .pop_i       (pop),
        .pop_data_o  (head_hit),
        .empty_o     (empty_o),
        .full_o      (full_o),
        .ovf_o       (overflow_o)
    );

    hro_ser #(.LANES(LANES)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .word_ok_i (!empty_o),
        .word_i    (head_hit),
        .pop_o     (pop),
        .frame_o   (frame_o),
        .lane_o    (lane_o)
    );

    // R7: no word can be started while reads are disabled or the store is empty
    a_r7_pop_gated: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (rd_en_i && !empty_o));
endmodule

// File: tb/sim_hit_readout_ddr.sv
`timescale 1ns/1ps
module sim_hit_readout_ddr;
    localparam real CLK_PERIOD = 5.0;
    localparam int  NV = 6;
    localparam logic [25:0] VEC [NV] = '{
        {6'h00, 10'h000, 10'h000},
        {6'h3F, 10'h3FF, 10'h3FF},
        {6'h15, 10'h2AA, 10'h155},
        {6'h2A, 10'h155, 10'h2AA},
        {6'h01, 10'h200, 10'h001},
        {6'h20, 10'h001, 10'h200}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid_i = 1'b0;
    logic [5:0] wr_chan_i = '0;
    logic [9:0] wr_amp_i = '0;
    logic [9:0] wr_time_i = '0;
    logic       rd_en_i = 1'b0;
    logic [1:0] lane_o;
    logic       frame_o, empty_o, full_o, overflow_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    hit_readout_ddr u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_chan_i(wr_chan_i),
        .wr_amp_i(wr_amp_i), .wr_time_i(wr_time_i), .rd_en_i(rd_en_i),
        .lane_o(lane_o), .frame_o(frame_o), .empty_o(empty_o), .full_o(full_o),
        .overflow_o(overflow_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_hit(input logic [25:0] v);
        wr_valid_i = 1'b1;
        {wr_chan_i, wr_amp_i, wr_time_i} = v;
        step();
        wr_valid_i = 1'b0;
    endtask

    // waits for a frame, then gathers 7 cycles of both phases on both lanes
    task automatic receive(output logic [27:0] w, output int gap, output bit fbad);
        gap  = 0;
        fbad = 0;
        w    = '0;
        while (frame_o !== 1'b1 && gap < 40) begin
            step();
            gap++;
        end
        if (gap >= 40) begin
            fbad = 1;
            return;
        end
        for (int c = 0; c < 7; c++) begin
            if (c > 0 && frame_o !== 1'b0) fbad = 1;
            #0.25;
            w[27-4*c] = lane_o[0];
            w[26-4*c] = lane_o[1];
            #2.5;
            w[25-4*c] = lane_o[0];
            w[24-4*c] = lane_o[1];
            @(posedge clk);
            #1;
        end
    endtask

    task automatic idle_cycles(input int n, output bit bad);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            #0.25;
            if (lane_o !== 2'b00 || frame_o !== 1'b0) bad = 1;
            #2.5;
            if (lane_o !== 2'b00) bad = 1;
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rd_en_i = 1'b0;
        wr_valid_i = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [27:0] w;
        int          gap;
        bit          fbad, bad;

        do_reset();
        // R1 reset state
        check(empty_o === 1'b1 && full_o === 1'b0 && overflow_o === 1'b0,
              "R1 flags", {29'd0, empty_o, full_o, overflow_o}, 32'h4);
        idle_cycles(2, bad);
        check(!bad, "R1 lanes idle after reset", bad, 0);

        // table walk: R2 format, R3 lane/phase order, R4 frame, R5 latency
        rd_en_i = 1'b1;
        for (int i = 0; i < NV; i++) begin
            write_hit(VEC[i]);
            receive(w, gap, fbad);
            check(w === {VEC[i], 2'b00}, "R2 R3 word", {4'd0, w}, {4'd0, VEC[i], 2'b00});
            check(gap == 1, "R5 latency", gap, 1);
            check(!fbad, "R4 frame first cycle only", fbad, 0);
        end
        idle_cycles(3, bad);
        check(!bad && empty_o === 1'b1, "R7 idle when empty", bad, 0);

        // R6 back-to-back, R8 order
        rd_en_i = 1'b0;
        for (int i = 0; i < 3; i++) write_hit(VEC[i+2]);
        rd_en_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            receive(w, gap, fbad);
            check(w === {VEC[i+2], 2'b00}, "R8 order", {4'd0, w}, {4'd0, VEC[i+2], 2'b00});
            check(gap == ((i == 0) ? 1 : 0), "R6 no gap", gap, (i == 0) ? 1 : 0);
        end

        // R8 full flag, R7 idle with reads disabled, R9 drop and sticky flag
        rd_en_i = 1'b0;
        for (int i = 0; i < 4; i++) write_hit(VEC[i]);
        check(full_o === 1'b1 && empty_o === 1'b0, "R8 full at 4",
              {30'd0, full_o, empty_o}, 32'h2);
        idle_cycles(3, bad);
        check(!bad, "R7 idle while reads disabled", bad, 0);
        write_hit(VEC[5]);
        check(overflow_o === 1'b1, "R9 overflow set", overflow_o, 1);
        check(full_o === 1'b1, "R9 still full", full_o, 1);
        rd_en_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            receive(w, gap, fbad);
            check(w === {VEC[i], 2'b00}, "R9 kept words", {4'd0, w}, {4'd0, VEC[i], 2'b00});
        end
        idle_cycles(12, bad);
        check(!bad && empty_o === 1'b1, "R9 dropped word absent", bad, 0);
        check(overflow_o === 1'b1, "R9 overflow sticky", overflow_o, 1);

        do_reset();
        check(overflow_o === 1'b0, "R1 overflow cleared by reset", overflow_o, 0);

        // R10 write and read at the same edge on a full buffer
        for (int i = 0; i < 4; i++) write_hit(VEC[i]);
        rd_en_i = 1'b1;
        write_hit(VEC[4]);
        check(full_o === 1'b1, "R10 still full", full_o, 1);
        check(overflow_o === 1'b0, "R10 no overflow", overflow_o, 0);
        for (int i = 0; i < 5; i++) begin
            receive(w, gap, fbad);
            check(w === {VEC[i], 2'b00}, "R10 all five words", {4'd0, w},
                  {4'd0, VEC[i], 2'b00});
            check(gap == 0, "R10 R6 continuous", gap, 0);
        end
        check(overflow_o === 1'b0 && empty_o === 1'b1, "R10 end state",
              {30'd0, overflow_o, empty_o}, 32'h1);

        // R11 rd_en low mid-word: current word finishes, next waits
        rd_en_i = 1'b0;
        write_hit(VEC[1]);
        write_hit(VEC[2]);
        rd_en_i = 1'b1;
        step();
        rd_en_i = 1'b0;
        receive(w, gap, fbad);
        check(w === {VEC[1], 2'b00} && gap == 0, "R11 word completes",
              {4'd0, w}, {4'd0, VEC[1], 2'b00});
        idle_cycles(10, bad);
        check(!bad && empty_o === 1'b0, "R11 no new word", bad, 0);
        rd_en_i = 1'b1;
        receive(w, gap, fbad);
        check(w === {VEC[2], 2'b00} && gap == 1, "R11 resumes",
              {4'd0, w}, {4'd0, VEC[2], 2'b00});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule